// File: doc/BRIEF.md
# Rotate Unit with Extend Flag

This execution unit performs the rotate operations of a legacy 16/32-bit processor on byte, word and long operands held in a 32-bit data register. It supports two modes. A plain rotate circulates the operand on itself. A rotate through the extend flag circulates a ring one bit wider than the operand, made of the extend flag above the operand's most significant bit. It returns the updated register value, in which only the operand-sized part changes, and new extend, negative, zero, overflow and carry flags.

The rotate count comes from one of three places: a 3-bit immediate field, the low six bits of a count register, or the single-bit word form used for memory operands. The count is reduced according to the mode and the operand size. The unit is registered. A request presented with `inValid` produces its result, together with `outValid`, on the next clock edge. Any count read from a register is sampled when the request is presented, so a count register that is also the destination supplies its value from before the operation.

Top module: `rot_ext_unit`

## Requirements
- R1: A request with `inValid` high at a rising clock edge makes `outValid` high after that edge and drives the result from then on. `outValid` is low after any edge with `inValid` low. Reset clears `outValid` and all result outputs to 0.
- R2: `opSize` encodes 0 = byte (8 bits), 1 = word (16 bits), 2 = long (32 bits), and 3 also means long. `rotLeft` = 1 rotates toward the MSB and 0 toward the LSB. `useExt` = 1 selects rotation through the extend flag and 0 selects plain rotation.
- R3: When `immMode` = 1 the count is `immCnt`, where codes 1 to 7 are taken as is and code 0 means 8.
- R4: When `immMode` = 0, only `cntReg[5:0]` is used, giving 0 to 63. A plain rotate applies that count modulo the operand width.
- R5: A rotation through the extend flag applies the 6-bit count modulo width+1 (9, 17 or 33) to the ring {extend, operand}. The new extend flag is the ring's top bit after the rotation.
- R6: In a plain rotate the extend flag is unchanged. The carry flag is the last bit rotated out: result bit 0 after a left rotate, and result MSB after a right rotate. When the unreduced count is 0, the carry flag is 0.
- R7: In a rotation through the extend flag, the carry flag equals the new extend flag. A reduced count of 0 leaves the operand and extend flag unchanged, so the carry flag equals the old extend flag.
- R8: The overflow flag is always 0. The negative flag is the result's MSB at the operand size. The zero flag is set when the operand-sized result is all zeros.
- R9: Byte and word operations return bits 31:8 and 31:16 of `dataIn` unchanged in `dataOut`.
- R10: When `memMode` = 1, the operation is a word rotate by exactly 1, whatever `opSize`, `immMode`, `immCnt` and `cntReg` hold. It works in either mode and either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| opSize | input | 2 | Operand size code |
| rotLeft | input | 1 | 1 = left, 0 = right |
| useExt | input | 1 | 1 = rotate through extend flag |
| immMode | input | 1 | 1 = count from immCnt |
| memMode | input | 1 | 1 = memory word form, count 1 |
| immCnt | input | 3 | Immediate count code |
| cntReg | input | 32 | Count register value |
| dataIn | input | 32 | Destination register value |
| extIn | input | 1 | Current extend flag |
| outValid | output | 1 | Result valid |
| dataOut | output | 32 | Updated register value |
| extOut | output | 1 | New extend flag |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |

## Verification
Several properties are checked on every cycle. The valid strobe must follow the request one cycle later. The reduced count must stay inside the ring length, and the immediate count must never be zero. The upper byte bits must survive a byte operation. The extend flag must be kept in plain mode, and the carry flag must track the new extend flag in extend mode. The carry flag must be clear after a zero count, and the zero flag must agree with a long result. The bench scenarios cover the actual rotated values, which the properties cannot show. These include the modulo-9, -17 and -33 reductions, the immediate code 0 meaning 8, the carry flag after a full-width plain rotate, and the memory form overriding the other count sources. Each result is compared against a bit-serial reference model.

// File: rtl/rot_unit_pkg.sv
package rot_unit_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int RING_W = DATA_W + 1;
  localparam int DBL_W  = 2 * RING_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } opSize_e;

  typedef struct packed {
    logic             load;
    logic             left;
    logic             useExt;
    logic             zeroRaw;
    opSize_e          sizeSel;
    logic [CNT_W-1:0] ringLen;
    logic [CNT_W-1:0] rotAmt;
  } rotStrobe_t;
endpackage

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSize,
  input  logic              rotLeft,
  input  logic              useExt,
  input  logic              immMode,
  input  logic              memMode,
  input  logic [2:0]        immCnt,
  input  logic [DATA_W-1:0] cntReg,
  output rotStrobe_t        strb
);
  opSize_e          effSize;
  logic [CNT_W-1:0] rawCnt;
  logic [CNT_W-1:0] width;

  always_comb begin
    if (memMode)                  effSize = SZ_WORD;
    else if (opSize == 2'd0)      effSize = SZ_BYTE;
    else if (opSize == 2'd1)      effSize = SZ_WORD;
    else                          effSize = SZ_LONG;

    case (effSize)
      SZ_BYTE: width = CNT_W'(8);
      SZ_WORD: width = CNT_W'(16);
      default: width = CNT_W'(32);
    endcase

    if (memMode)                  rawCnt = CNT_W'(1);
    else if (immMode)             rawCnt = (immCnt == 3'd0) ? CNT_W'(8) : CNT_W'(immCnt);
    else                          rawCnt = cntReg[CNT_W-1:0];
  end

  always_comb begin
    strb         = '0;
    strb.load    = inValid;
    strb.left    = rotLeft;
    strb.useExt  = useExt;
    strb.zeroRaw = (rawCnt == '0);
    strb.sizeSel = effSize;
    if (useExt) begin
      strb.ringLen = width + CNT_W'(1);
      case (effSize)
        SZ_BYTE: strb.rotAmt = rawCnt % CNT_W'(9);
        SZ_WORD: strb.rotAmt = rawCnt % CNT_W'(17);
        default: strb.rotAmt = rawCnt % CNT_W'(33);
      endcase
    end else begin
      strb.ringLen = width;
      strb.rotAmt  = rawCnt & (width - CNT_W'(1));
    end
  end

  AST_AMT_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (strb.rotAmt < strb.ringLen)); // R5

  AST_IMM_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && immMode && !memMode) |-> !strb.zeroRaw); // R3
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rotStrobe_t        strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              extIn,
  output logic              outValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              extOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  logic [CNT_W-1:0]  width;
  logic [DATA_W-1:0] wMask;
  logic [RING_W-1:0] ring;
  logic [DBL_W-1:0]  dbl;
  logic [DBL_W-1:0]  ringMask;
  logic [DBL_W-1:0]  leftRot;
  logic [DBL_W-1:0]  rightRot;
  logic [RING_W-1:0] rotRing;
  logic [DATA_W-1:0] res;
  logic              newExt;
  logic              msb;
  logic              cNext;
  logic [DATA_W-1:0] merged;

  always_comb begin
    case (strb.sizeSel)
      SZ_BYTE: begin width = CNT_W'(8);  wMask = 32'h0000_00FF; end
      SZ_WORD: begin width = CNT_W'(16); wMask = 32'h0000_FFFF; end
      default: begin width = CNT_W'(32); wMask = 32'hFFFF_FFFF; end
    endcase

    ring = {1'b0, dataIn & wMask};
    if (strb.useExt) ring = ring | (RING_W'(extIn) << width);

    dbl      = ({{RING_W{1'b0}}, ring} << strb.ringLen) | {{RING_W{1'b0}}, ring};
    ringMask = (DBL_W'(1) << strb.ringLen) - DBL_W'(1);
    leftRot  = ((dbl << strb.rotAmt) >> strb.ringLen) & ringMask;
    rightRot = (dbl >> strb.rotAmt) & ringMask;
    rotRing  = strb.left ? leftRot[RING_W-1:0] : rightRot[RING_W-1:0];

    res    = rotRing[DATA_W-1:0] & wMask;
    newExt = strb.useExt ? rotRing[width] : extIn;
    msb    = res[width - CNT_W'(1)];

    if (strb.useExt)        cNext = newExt;
    else if (strb.zeroRaw)  cNext = 1'b0;
    else if (strb.left)     cNext = res[0];
    else                    cNext = msb;

    merged = (dataIn & ~wMask) | res;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dataOut  <= '0;
      extOut   <= 1'b0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
    end else begin
      outValid <= strb.load;
      if (strb.load) begin
        dataOut <= merged;
        extOut  <= newExt;
        flagN   <= msb;
        flagZ   <= (res == '0);
        flagV   <= 1'b0;
        flagC   <= cNext;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid); // R1

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !outValid); // R1

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.sizeSel == SZ_BYTE) |=> (dataOut[31:8] == $past(dataIn[31:8]))); // R9

  AST_PLAIN_EXT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.useExt) |=> (extOut == $past(extIn))); // R6

  AST_ZERO_CNT_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.useExt && strb.zeroRaw) |=> !flagC); // R6

  AST_EXT_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.useExt) |=> (flagC == extOut)); // R7

  AST_LONG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.sizeSel == SZ_LONG) |=> (flagZ == (dataOut == '0))); // R8
endmodule

// File: rtl/rot_ext_unit.sv
module rot_ext_unit
  import rot_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSize,
  input  logic        rotLeft,
  input  logic        useExt,
  input  logic        immMode,
  input  logic        memMode,
  input  logic [2:0]  immCnt,
  input  logic [31:0] cntReg,
  input  logic [31:0] dataIn,
  input  logic        extIn,
  output logic        outValid,
  output logic [31:0] dataOut,
  output logic        extOut,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagV,
  output logic        flagC
);
  rotStrobe_t strb;

  rot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSize(opSize),
    .rotLeft(rotLeft), .useExt(useExt), .immMode(immMode), .memMode(memMode),
    .immCnt(immCnt), .cntReg(cntReg), .strb(strb)
  );

  rot_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .extIn(extIn),
    .outValid(outValid), .dataOut(dataOut), .extOut(extOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );
endmodule

// File: tb/tb_rot_ext_unit.sv
module tb_rot_ext_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSize = '0;
  logic        rotLeft = 1'b0, useExt = 1'b0, immMode = 1'b0, memMode = 1'b0;
  logic [2:0]  immCnt = '0;
  logic [31:0] cntReg = '0, dataIn = '0;
  logic        extIn = 1'b0;
  logic        outValid, extOut, flagN, flagZ, flagV, flagC;
  logic [31:0] dataOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_ext_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSize(opSize), .rotLeft(rotLeft),
    .useExt(useExt), .immMode(immMode), .memMode(memMode), .immCnt(immCnt),
    .cntReg(cntReg), .dataIn(dataIn), .extIn(extIn), .outValid(outValid),
    .dataOut(dataOut), .extOut(extOut), .flagN(flagN), .flagZ(flagZ),
    .flagV(flagV), .flagC(flagC)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial reference: one single-bit step per count unit.
  task automatic refModel(input logic [1:0] sz, input logic lft, input logic ux,
                          input logic im, input logic mem, input logic [2:0] ic,
                          input logic [31:0] cr, input logic [31:0] d, input logic xi,
                          output logic [31:0] eD, output logic eX, output logic eN,
                          output logic eZ, output logic eC);
    int w, raw, k;
    logic [31:0] mask, op;
    logic xx, t;
    w = mem ? 16 : (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    raw = mem ? 1 : im ? ((ic == 3'd0) ? 8 : int'(ic)) : int'(cr[5:0]);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    op = d & mask;
    xx = xi;
    if (ux) begin
      k = raw % (w + 1);
      for (int i = 0; i < k; i++) begin
        if (lft) begin t = op[w-1]; op = ((op << 1) | 32'(xx)) & mask; xx = t; end
        else     begin t = op[0];   op = (op >> 1) | (32'(xx) << (w-1));  xx = t; end
      end
      eC = xx;
    end else begin
      k = raw % w;
      for (int i = 0; i < k; i++) begin
        if (lft) op = ((op << 1) | 32'(op[w-1])) & mask;
        else     op = (op >> 1) | (32'(op[0]) << (w-1));
      end
      eC = (raw == 0) ? 1'b0 : (lft ? op[0] : op[w-1]);
    end
    eX = xx;
    eN = op[w-1];
    eZ = (op == 32'd0);
    eD = (d & ~mask) | op;
  endtask

  task automatic runOp(input string req, input logic [1:0] sz, input logic lft,
                       input logic ux, input logic im, input logic mem,
                       input logic [2:0] ic, input logic [31:0] cr,
                       input logic [31:0] d, input logic xi);
    logic [31:0] eD;
    logic eX, eN, eZ, eC;
    refModel(sz, lft, ux, im, mem, ic, cr, d, xi, eD, eX, eN, eZ, eC);
    @(negedge clk);
    inValid = 1'b1; opSize = sz; rotLeft = lft; useExt = ux; immMode = im;
    memMode = mem; immCnt = ic; cntReg = cr; dataIn = d; extIn = xi;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, 64'(outValid), 64'(1'b1));
    check({req, " result"}, {27'd0, dataOut, extOut, flagN, flagZ, flagV, flagC},
                            {27'd0, eD, eX, eN, eZ, 1'b0, eC});
  endtask

  task automatic tReset();
    check("R1 reset state", {25'd0, outValid, dataOut, extOut, flagN, flagZ, flagV, flagC}, 64'd0);
  endtask

  task automatic tImmediate();
    runOp("R3 R2 byte left imm 3",  2'd0, 1, 0, 1, 0, 3'd3, 32'h0, 32'h0000_0081, 0);
    runOp("R3 imm code0 is 8 word", 2'd1, 0, 0, 1, 0, 3'd0, 32'h0, 32'h0000_1234, 0);
    runOp("R3 imm code0 ext byte",  2'd0, 1, 1, 1, 0, 3'd0, 32'h0, 32'h0000_00A5, 1);
  endtask

  task automatic tRegPlain();
    runOp("R4 long count 35",       2'd2, 1, 0, 0, 0, 3'd0, 32'hFFFF_FF23, 32'h8000_0001, 1);
    runOp("R6 count 64 clears C",   2'd2, 0, 0, 0, 0, 3'd0, 32'h0000_0040, 32'h8000_0001, 0);
    runOp("R6 full width right C",  2'd2, 0, 0, 0, 0, 3'd0, 32'h0000_0020, 32'h8000_0000, 0);
    runOp("R2 size code 3 long",    2'd3, 0, 0, 0, 0, 3'd0, 32'h0000_0004, 32'h1234_5678, 1);
  endtask

  task automatic tExtend();
    runOp("R7 byte count 9 no-op",  2'd0, 1, 1, 0, 0, 3'd0, 32'h0000_0009, 32'h0000_003C, 1);
    runOp("R5 word right 5",        2'd1, 0, 1, 0, 0, 3'd0, 32'h0000_0005, 32'h0000_F00F, 1);
    runOp("R7 long count 33",       2'd2, 0, 1, 0, 0, 3'd0, 32'h0000_0021, 32'hDEAD_BEEF, 0);
    runOp("R5 long count 40",       2'd2, 1, 1, 0, 0, 3'd0, 32'h0000_0028, 32'h8765_4321, 1);
    runOp("R5 word count 17+1",     2'd1, 1, 1, 0, 0, 3'd0, 32'h0000_0012, 32'h0000_8000, 0);
  endtask

  task automatic tFlags();
    runOp("R8 zero result",         2'd0, 1, 0, 1, 0, 3'd2, 32'h0, 32'hFFFF_FF00, 1);
    runOp("R8 negative word",       2'd1, 0, 0, 1, 0, 3'd1, 32'h0, 32'h0000_0001, 0);
  endtask

  task automatic tUpper();
    runOp("R9 byte keeps upper",    2'd0, 0, 1, 0, 0, 3'd0, 32'h0000_0003, 32'hCAFE_BA5E, 1);
    runOp("R9 word keeps upper",    2'd1, 1, 0, 0, 0, 3'd0, 32'h0000_0007, 32'h5A5A_8001, 0);
  endtask

  task automatic tMemory();
    runOp("R10 mem left ext",       2'd0, 1, 1, 1, 1, 3'd5, 32'h0000_0013, 32'hAAAA_8001, 0);
    runOp("R10 mem right plain",    2'd2, 0, 0, 0, 1, 3'd0, 32'h0000_0000, 32'h1111_0001, 1);
  endtask

  task automatic tIdle();
    @(negedge clk);
    check("R1 valid drops", 64'(outValid), 64'(1'b0));
  endtask

  task automatic tSweep();
    logic [31:0] lfsr = 32'hACE1_1234;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      runOp("R2 R4 R5 sweep", lfsr[1:0], lfsr[2], lfsr[3], lfsr[4], 1'b0,
            lfsr[7:5], {26'd0, lfsr[13:8]}, lfsr ^ 32'h5A3C_96E1, lfsr[14]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tImmediate();
    tIdle();
    tRegPlain();
    tExtend();
    tFlags();
    tUpper();
    tMemory();
    tSweep();
    tIdle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule